// File: doc/BRIEF.md
# Multiplexed External Memory Bus Interface

This block is the off-chip bus side of a small 8-bit controller with a 16-bit address space. The core hands it one access at a time: a code fetch, a data read or a data write. For a code fetch it first decides whether the byte comes from on-chip ROM or from outside. The decision depends on the external-access level and on the address. On-chip ROM contents come from a stub that computes a fixed pattern.

An off-chip access takes one machine cycle of twelve clocks. The controller first drives the low address byte on the shared port 0 and the high byte on port 2, with the address-latch strobe high. The latch strobe then falls, so an external transparent latch holds the low byte. The port keeps the address for a short setup window. Next, one of three active-low strobes goes low for five clocks: program-store enable for code, read for data reads, or write for data writes. During a read strobe port 0 is released, and the byte on it is captured when the strobe rises. During a write strobe port 0 carries the write data. A data access may use an 8-bit pointer, which confines it to the first 256 bytes, or a 16-bit pointer.

The state machine has six states. IDLE goes to INTERNAL on an accepted on-chip fetch, or to ADDR on an accepted off-chip access. INTERNAL returns to IDLE after twelve clocks. The off-chip path runs ADDR (4 clocks) to LATCH (2 clocks) to STROBE (5 clocks) to HOLD (1 clock), and then back to IDLE. The response pulse is raised on both transitions into IDLE.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset the address-latch strobe is 0, all three active-low strobes are 1, port 0 is not driven, both port outputs are 00h, busy is 0, the response pulse is 0 and the response data is 00h.
- R2: A code fetch (kind 0) with ext_access=1 and an address below 1000h is served on-chip. It keeps busy high for 12 clocks and raises no latch strobe and no active-low strobe. It leaves port 0 undriven and leaves both port output values unchanged. The response data is the stub byte, which is addr[7:0] XOR {addr[11:8],addr[11:8]} XOR 5Ah.
- R3: A code fetch goes off-chip when ext_access=1 and the address is 1000h or above, and always when ext_access=0.
- R4: An off-chip access begins with the latch strobe high for the first 4 clocks after acceptance. During that time port 0 is driven with A7..A0 and port 2 carries A15..A8, and both stay stable.
- R5: After the latch strobe falls, port 0 keeps the low address for 2 clocks. Then exactly one strobe is low for the next 5 clocks, and a single hold clock follows. The strobe is program-store enable for kind 0, read for kinds 1 and 3, and write for kind 2. No two strobes are ever low together.
- R6: For reads (kinds 0, 1 and 3), port 0 is undriven while the strobe is low and during the hold clock. The byte on p0_in in the last strobe clock becomes the response data.
- R7: For a write (kind 2), port 0 is driven with the write data while the strobe is low and during the hold clock. The response data keeps its previous value.
- R8: A data access with req_wide=0 puts 00h on port 2. A code fetch and a data access with req_wide=1 put the address high byte there.
- R9: The response pulse is high for exactly one clock, on the clock after the twelfth busy clock. Busy is low at that time. A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request presented; accepted only when not busy |
| req_kind | input | 2 | 0 code fetch, 1 data read, 2 data write, 3 treated as data read |
| req_wide | input | 1 | Data pointer width: 1 = 16-bit, 0 = 8-bit |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| ext_access | input | 1 | 1 = low code space is on-chip, 0 = all code is off-chip |
| p0_in | input | 8 | Value sensed on port 0 pins |
| p0_out | output | 8 | Port 0 output value (address low byte or write data) |
| p0_oe | output | 1 | Port 0 output enable |
| p2_out | output | 8 | Port 2 output value (address high byte) |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| busy | output | 1 | Access in progress |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_data | output | 8 | Returned read data, held until the next read |

## Verification
The properties assume that the phase timing is left at its defaults. They also assume that rsp_valid cannot be seen while a new access is starting, which holds only when the core waits for the response before issuing again. The stimulus keeps to this by issuing each request from an idle controller after the previous response pulse. Requests that arrive while busy are driven only to show that they are ignored. The bench's external memory answers on p0_in only while psen_n or rd_n is low, and it otherwise returns a pull-up value, so the value captured at the strobe rise is the memory's.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [1:0] {
        ACC_CODE   = 2'd0,
        ACC_DREAD  = 2'd1,
        ACC_DWRITE = 2'd2,
        ACC_RSVD   = 2'd3
    } acc_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INTERNAL,
        ST_ADDR,
        ST_LATCH,
        ST_STROBE,
        ST_HOLD
    } bus_state_t;

    // Placeholder on-chip ROM pattern
    function automatic logic [7:0] rom_pattern(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction

    function automatic logic kind_is_read(input acc_kind_t k);
        return k != ACC_DWRITE;
    endfunction

endpackage

// File: rtl/xbus_rom_stub.sv
module xbus_rom_stub (
    input  logic [15:0] addr,
    output logic [7:0]  data
);
    import xbus_pkg::*;

    always_comb data = rom_pattern(addr);

endmodule

// File: rtl/xbus_route.sv
module xbus_route #(
    parameter int INT_ROM_BYTES = 4096
) (
    input  logic [1:0]  req_kind,
    input  logic        req_wide,
    input  logic [15:0] req_addr,
    input  logic        ext_access,
    output logic        go_internal,
    output logic [7:0]  addr_hi
);
    import xbus_pkg::*;

    localparam logic [16:0] ROM_LIMIT = 17'(INT_ROM_BYTES);

    logic is_code;

    always_comb begin
        is_code     = acc_kind_t'(req_kind) == ACC_CODE;
        go_internal = is_code && ext_access && ({1'b0, req_addr} < ROM_LIMIT);
        addr_hi     = (!is_code && !req_wide) ? 8'h00 : req_addr[15:8];
    end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq #(
    parameter int ALE_CLKS    = 4,
    parameter int SETUP_CLKS  = 2,
    parameter int STROBE_CLKS = 5,
    parameter int HOLD_CLKS   = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic [7:0]  req_addr_lo,
    input  logic [7:0]  req_wdata,
    input  logic        go_internal,
    input  logic [7:0]  addr_hi,
    input  logic [7:0]  p0_in,
    input  logic [7:0]  rom_byte,
    output logic [15:0] lat_addr,
    output logic [7:0]  p0_out,
    output logic        p0_oe,
    output logic [7:0]  p2_out,
    output logic        ale,
    output logic        psen_n,
    output logic        rd_n,
    output logic        wr_n,
    output logic        busy,
    output logic        rsp_valid,
    output logic [7:0]  rsp_data
);
    import xbus_pkg::*;

    localparam int CYCLE_CLKS = ALE_CLKS + SETUP_CLKS + STROBE_CLKS + HOLD_CLKS;
    localparam int CW         = $clog2(CYCLE_CLKS + 1);

    bus_state_t       state_q, state_d;
    logic [CW-1:0]    cnt_q;
    acc_kind_t        kind_q;
    logic [15:0]      addr_q;
    logic [7:0]       wdata_q;

    logic             accept;
    logic             phase_end;
    acc_kind_t        eff_kind;
    logic [7:0]       eff_lo, eff_hi, eff_wdata;

    function automatic int phase_len(input bus_state_t s);
        unique case (s)
            ST_INTERNAL: return CYCLE_CLKS;
            ST_ADDR:     return ALE_CLKS;
            ST_LATCH:    return SETUP_CLKS;
            ST_STROBE:   return STROBE_CLKS;
            ST_HOLD:     return HOLD_CLKS;
            default:     return 1;
        endcase
    endfunction

    always_comb begin
        accept    = (state_q == ST_IDLE) && req_valid;
        phase_end = cnt_q == CW'(phase_len(state_q) - 1);
        eff_kind  = accept ? acc_kind_t'(req_kind) : kind_q;
        eff_lo    = accept ? req_addr_lo : addr_q[7:0];
        eff_hi    = accept ? addr_hi     : addr_q[15:8];
        eff_wdata = accept ? req_wdata   : wdata_q;
        busy      = state_q != ST_IDLE;
        lat_addr  = addr_q;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = go_internal ? ST_INTERNAL : ST_ADDR;
            ST_INTERNAL: if (phase_end) state_d = ST_IDLE;
            ST_ADDR:     if (phase_end) state_d = ST_LATCH;
            ST_LATCH:    if (phase_end) state_d = ST_STROBE;
            ST_STROBE:   if (phase_end) state_d = ST_HOLD;
            ST_HOLD:     if (phase_end) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register, phase counter and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            kind_q  <= ACC_CODE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q || state_q == ST_IDLE)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
            if (accept) begin
                kind_q  <= acc_kind_t'(req_kind);
                addr_q  <= {addr_hi, req_addr_lo};
                wdata_q <= req_wdata;
            end
        end
    end

    // Registered outputs, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale       <= 1'b0;
            psen_n    <= 1'b1;
            rd_n      <= 1'b1;
            wr_n      <= 1'b1;
            p0_out    <= '0;
            p0_oe     <= 1'b0;
            p2_out    <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            ale    <= state_d == ST_ADDR;
            psen_n <= !(state_d == ST_STROBE && eff_kind == ACC_CODE);
            wr_n   <= !(state_d == ST_STROBE && eff_kind == ACC_DWRITE);
            rd_n   <= !(state_d == ST_STROBE && eff_kind != ACC_CODE && kind_is_read(eff_kind));

            unique case (state_d)
                ST_ADDR: begin
                    p0_out <= eff_lo;
                    p2_out <= eff_hi;
                    p0_oe  <= 1'b1;
                end
                ST_LATCH: p0_oe <= 1'b1;
                ST_STROBE, ST_HOLD: begin
                    if (eff_kind == ACC_DWRITE) begin
                        p0_out <= eff_wdata;
                        p0_oe  <= 1'b1;
                    end else begin
                        p0_oe  <= 1'b0;
                    end
                end
                default: p0_oe <= 1'b0;
            endcase

            rsp_valid <= (state_q == ST_HOLD || state_q == ST_INTERNAL) && state_d == ST_IDLE;

            if (state_q == ST_STROBE && state_d == ST_HOLD && kind_is_read(kind_q))
                rsp_data <= p0_in;
            else if (state_q == ST_INTERNAL && state_d == ST_IDLE)
                rsp_data <= rom_byte;
        end
    end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
    parameter int ALE_CLKS      = 4,
    parameter int SETUP_CLKS    = 2,
    parameter int STROBE_CLKS   = 5,
    parameter int HOLD_CLKS     = 1,
    parameter int INT_ROM_BYTES = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic        req_wide,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_wdata,
    input  logic        ext_access,
    input  logic [7:0]  p0_in,
    output logic [7:0]  p0_out,
    output logic        p0_oe,
    output logic [7:0]  p2_out,
    output logic        ale,
    output logic        psen_n,
    output logic        rd_n,
    output logic        wr_n,
    output logic        busy,
    output logic        rsp_valid,
    output logic [7:0]  rsp_data
);
    logic        go_internal;
    logic [7:0]  addr_hi;
    logic [15:0] lat_addr;
    logic [7:0]  rom_byte;

    xbus_route #(.INT_ROM_BYTES(INT_ROM_BYTES)) u_route (
        .req_kind    (req_kind),
        .req_wide    (req_wide),
        .req_addr    (req_addr),
        .ext_access  (ext_access),
        .go_internal (go_internal),
        .addr_hi     (addr_hi)
    );

    xbus_rom_stub u_rom (
        .addr (lat_addr),
        .data (rom_byte)
    );

    xbus_seq #(
        .ALE_CLKS    (ALE_CLKS),
        .SETUP_CLKS  (SETUP_CLKS),
        .STROBE_CLKS (STROBE_CLKS),
        .HOLD_CLKS   (HOLD_CLKS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .req_addr_lo (req_addr[7:0]),
        .req_wdata   (req_wdata),
        .go_internal (go_internal),
        .addr_hi     (addr_hi),
        .p0_in       (p0_in),
        .rom_byte    (rom_byte),
        .lat_addr    (lat_addr),
        .p0_out      (p0_out),
        .p0_oe       (p0_oe),
        .p2_out      (p2_out),
        .ale         (ale),
        .psen_n      (psen_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .busy        (busy),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data)
    );

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] p0_out,
    input logic       p0_oe,
    input logic [7:0] p2_out,
    input logic       ale,
    input logic       psen_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic       busy,
    input logic       rsp_valid
);
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!psen_n, !rd_n, !wr_n})); // R5

    AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (psen_n && rd_n && wr_n && p0_oe)); // R4

    AST_ALE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && $past(ale)) |-> ($stable(p0_out) && $stable(p2_out))); // R4

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n) |-> !p0_oe); // R6

    AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (p0_oe && busy)); // R7

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9

    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !busy); // R9

    AST_ALE_FALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> ($stable(p0_out) && p0_oe && busy)); // R5

endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .p0_out    (p0_out),
    .p0_oe     (p0_oe),
    .p2_out    (p2_out),
    .ale       (ale),
    .psen_n    (psen_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .busy      (busy),
    .rsp_valid (rsp_valid)
);

// File: tb/tb_xbus_ctrl.sv
module tb_xbus_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        req_wide = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        ext_access = 1'b1;
    logic [7:0]  p0_in;
    logic [7:0]  p0_out;
    logic        p0_oe;
    logic [7:0]  p2_out;
    logic        ale, psen_n, rd_n, wr_n, busy, rsp_valid;
    logic [7:0]  rsp_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    xbus_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .ext_access(ext_access), .p0_in(p0_in), .p0_out(p0_out), .p0_oe(p0_oe),
        .p2_out(p2_out), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // External memory model with an address latch on the falling latch strobe
    logic [15:0] ext_lat = 16'h0;
    logic [7:0]  xram [logic [15:0]];

    function automatic logic [7:0] code_fn(input logic [15:0] a);
        return a[15:8] + a[7:0] + 8'd1;
    endfunction

    function automatic logic [7:0] xram_rd(input logic [15:0] a);
        if (xram.exists(a)) return xram[a];
        return a[7:0] ^ a[15:8] ^ 8'hC3;
    endfunction

    always @(negedge ale) ext_lat = {p2_out, p0_out};
    always @(posedge wr_n) if (rst_n) xram[ext_lat] = p0_out;

    assign p0_in = !psen_n ? code_fn(ext_lat) : (!rd_n ? xram_rd(ext_lat) : 8'hFF);

    // Model state
    logic [7:0] m_p0   = 8'h00;
    logic [7:0] m_p2   = 8'h00;
    logic [7:0] m_rsp  = 8'h00;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // kind: 0 code, 1 read, 2 write, 3 read; poke drives a request while busy
    task automatic run_txn(input logic [1:0] kind, input logic wide, input logic [15:0] addr,
                           input logic [7:0] wdata, input logic ext, input bit poke);
        bit internal, is_wr;
        logic [7:0] hi, lo, exp_rsp;
        logic [15:0] eaddr;
        internal = (kind == 2'd0) && ext && (addr < 16'h1000);
        is_wr    = kind == 2'd2;
        hi       = (kind != 2'd0 && !wide) ? 8'h00 : addr[15:8];
        lo       = addr[7:0];
        eaddr    = {hi, lo};
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_wide = wide;
        req_addr = addr; req_wdata = wdata; ext_access = ext;
        for (int n = 1; n <= 13; n++) begin
            @(negedge clk);
            if (n == 1) req_valid = 1'b0;
            if (poke && n == 3) begin
                req_valid = 1'b1; req_kind = 2'd2; req_wide = 1'b1;
                req_addr = 16'hBEEF; req_wdata = 8'h99; ext_access = 1'b0;
            end
            if (poke && n == 6) req_valid = 1'b0;
            chk("R9", "busy", busy, n <= 12);
            chk("R9", "rsp_valid", rsp_valid, n == 13);
            if (internal) begin
                chk("R2", "ale", ale, 0);
                chk("R2", "strobes", {psen_n, rd_n, wr_n}, 3'b111);
                chk("R2", "p0_oe", p0_oe, 0);
                chk("R2", "p0_out", p0_out, m_p0);
                chk("R2", "p2_out", p2_out, m_p2);
                if (n == 13) begin
                    exp_rsp = addr[7:0] ^ {addr[11:8], addr[11:8]} ^ 8'h5A;
                    chk("R2", "rom data", rsp_data, exp_rsp);
                    m_rsp = exp_rsp;
                end
            end else begin
                chk("R4", "ale", ale, n <= 4);
                chk("R8", "p2_out", p2_out, hi);
                chk("R5", "psen_n", psen_n, !(n >= 7 && n <= 11 && kind == 2'd0));
                chk("R5", "rd_n", rd_n, !(n >= 7 && n <= 11 && (kind == 2'd1 || kind == 2'd3)));
                chk("R5", "wr_n", wr_n, !(n >= 7 && n <= 11 && is_wr));
                if (n <= 6) begin
                    chk("R4", "p0_oe addr", p0_oe, 1);
                    chk("R4", "p0_out addr", p0_out, lo);
                end else if (n <= 12) begin
                    if (is_wr) begin
                        chk("R7", "p0_oe data", p0_oe, 1);
                        chk("R7", "p0_out data", p0_out, wdata);
                    end else begin
                        chk("R6", "p0_oe released", p0_oe, 0);
                    end
                end else begin
                    chk("R6", "p0_oe idle", p0_oe, 0);
                end
                if (n == 13) begin
                    if (is_wr) begin
                        chk("R7", "rsp_data kept", rsp_data, m_rsp);
                        xram[eaddr] = wdata;
                    end else begin
                        exp_rsp = (kind == 2'd0) ? code_fn(eaddr) : xram_rd(eaddr);
                        chk(kind == 2'd0 ? "R3" : "R6", "read data", rsp_data, exp_rsp);
                        m_rsp = exp_rsp;
                    end
                    m_p2 = hi;
                    m_p0 = is_wr ? wdata : lo;
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "ale", ale, 0);
        chk("R1", "strobes", {psen_n, rd_n, wr_n}, 3'b111);
        chk("R1", "p0_oe", p0_oe, 0);
        chk("R1", "ports", {p2_out, p0_out}, 16'h0000);
        chk("R1", "busy", busy, 0);
        chk("R1", "rsp", {rsp_valid, rsp_data}, 9'h000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_txn(2'd0, 1'b1, 16'h0123, 8'h00, 1'b1, 0); // R2 internal
        run_txn(2'd0, 1'b1, 16'h0FFF, 8'h00, 1'b1, 0); // R2 top of on-chip range
        run_txn(2'd0, 1'b1, 16'h1000, 8'h00, 1'b1, 0); // R3 first off-chip code
        run_txn(2'd0, 1'b1, 16'h0040, 8'h00, 1'b0, 0); // R3 ext_access low
        run_txn(2'd2, 1'b1, 16'h8A55, 8'h3C, 1'b1, 0); // R7 wide write
        run_txn(2'd1, 1'b1, 16'h8A55, 8'h00, 1'b1, 0); // R6 read back
        run_txn(2'd2, 1'b0, 16'h1277, 8'hE1, 1'b1, 0); // R8 narrow write
        run_txn(2'd1, 1'b1, 16'h0077, 8'h00, 1'b1, 0); // R8 lands in page 0
        run_txn(2'd1, 1'b0, 16'hFF10, 8'h00, 1'b0, 0); // R8 narrow read
        run_txn(2'd0, 1'b1, 16'h0ABC, 8'h00, 1'b1, 0); // R2 ports unchanged
        run_txn(2'd1, 1'b1, 16'h4321, 8'h00, 1'b1, 1); // R9 request while busy
        run_txn(2'd3, 1'b1, 16'hC0DE, 8'h00, 1'b1, 0); // R5 kind 3 reads
        run_txn(2'd0, 1'b1, 16'hFFFF, 8'h00, 1'b0, 0); // R3 top code
        repeat (3) @(negedge clk);
        chk("R9", "idle after", {busy, rsp_valid}, 2'b00);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule